// File: doc/BRIEF.md
# Chip-Select Gated Transmit Header Loader

This block sits in front of the transmit path of a serial peripheral that is clocked by a remote controller. Software places a header of one to four bytes into the block, and the block decides whether those bytes may enter the transmit path. That decision depends on the chip-select line and on the gating mode. Accepted bytes go out on a simple push interface, one byte per clock, least-significant byte first. The push interface stands in for the transmit FIFO.

Two gating modes exist. In gated mode software arms the block with an enable bit, and the header is committed once the synchronised chip select is seen low. Any header write made while chip select is low, or after a commit, is refused. In free mode every header write arms the block by itself. A header staged while chip select is high is committed at the falling edge of chip select. If nothing was staged, the first write made while chip select is low is committed at once. Two sticky flags record whether a header was committed and whether a write was refused. Software clears each flag by writing 0 to its bit.

Top module: `hdr_commit_ctrl`

## Requirements
- R1: After synchronous reset all status bits are 0: free mode, enable clear, both flags clear. push_valid is low.
- R2: A write strobe on bit k of hdr_wr (k = 0..3) loads k+1 bytes taken from the low bytes of hdr_wdata. If several strobe bits are set, the highest one decides the length.
- R3: A committed header is pushed one byte per cycle, byte 0 (hdr_wdata[7:0]) first. push_valid is high for exactly as many cycles as the header has bytes, starting in the cycle after the commit edge. Nothing is pushed without a commit.
- R4: cs_n_in passes through a two-flop synchroniser. A falling edge on it produces a commit on the third rising clock edge after the change, and not earlier.
- R5: In free mode (stat[0] = 0) any header write sets the enable bit stat[1].
- R6: In free mode, a header written while chip select is high is held and not pushed until the synchronised falling edge of chip select. At that edge it is committed and stat[2] is set.
- R7: In free mode, with nothing held and chip select low, a header write is committed in the next cycle, and its bytes are pushed.
- R8: In gated mode (stat[0] = 1) the enable bit changes only through control writes. The block commits when the enable bit is set and the synchronised chip select is low. A header write made while chip select is low is refused.
- R9: A refused header write sets stat[3] and pushes no byte. A write is refused if the committed flag is already set, or if bytes are still being pushed, or in gated mode if chip select is low.
- R10: A control write loads the mode (bit 0) and the enable bit (bit 1). On bit 2 (committed) and bit 3 (ignored), writing 0 clears the flag and writing 1 leaves it unchanged. A setting event in the same cycle wins over the clear. stat uses the same bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_in | input | 1 | Asynchronous chip select from the remote controller, active low |
| hdr_wr | input | 4 | Header write strobes; bit k writes k+1 bytes |
| hdr_wdata | input | 32 | Header bytes, byte 0 in bits 7:0 |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 4 | Control value: mode, enable, committed-clear, ignored-clear |
| stat | output | 4 | Mode, enable, committed flag, ignored flag |
| push_valid | output | 1 | A header byte is presented to the transmit path |
| push_data | output | 8 | Header byte being pushed |

## Verification
A wrong flag state shows up on stat in the cycle after the event that caused it. A wrong commit decision is visible one cycle after the write, or three cycles after chip select falls. It shows either as a stray or missing burst on push_valid, or as bytes in the wrong order or of the wrong count within the following four cycles. A refused write that leaks into the staging register does not show until the next commit. For that reason every scenario drains the push interface completely and compares the whole collected header word. Scenarios that refuse a second write are included, so that the first header must come out unchanged.

// File: rtl/hdr_commit_pkg.sv
// Shared constants for the header commit controller: control/status bit
// positions. Assumes a 4-bit control and status word.
package hdr_commit_pkg;
    localparam int CTL_W     = 4;
    localparam int BIT_GATE  = 0;  // 1 = gated mode, 0 = free mode
    localparam int BIT_EN    = 1;  // header enable
    localparam int BIT_DONE  = 2;  // committed flag
    localparam int BIT_DROP  = 3;  // ignored flag
endpackage

// File: rtl/hdr_cs_sync.sv
// Chip-select synchroniser with falling-edge detector.
// Assumes cs_n_async is asynchronous to clk; resets to the inactive (high) level.
module hdr_cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_async,
    output logic cs_n_q,
    output logic cs_fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // One flop of the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[i] <= 1'b1;
                else if (i == 0)
                    chain[i] <= cs_n_async;
                else
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign cs_n_q  = chain[STAGES-1];
    assign cs_fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/hdr_stage.sv
// Header write decoder and staging register.
// Decodes the one-per-length write strobes (highest bit wins) and holds a
// header written while chip select is high until it is committed.
module hdr_stage #(
    parameter int MAX_BYTES = 4,
    parameter int BYTE_W    = 8,
    localparam int DATA_W   = MAX_BYTES * BYTE_W,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MAX_BYTES-1:0] wr_strobe,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 load,
    input  logic                 clear,
    output logic                 wr_any,
    output logic [CNT_W-1:0]     wr_len,
    output logic [CNT_W-1:0]     st_len,
    output logic [DATA_W-1:0]    st_data
);
    // Byte count of the current write: highest strobe bit decides.
    always_comb begin
        wr_len = '0;
        for (int k = 0; k < MAX_BYTES; k++)
            if (wr_strobe[k]) wr_len = CNT_W'(k + 1);
    end

    assign wr_any = |wr_strobe;

    // Staging register: loaded by an accepted early write, emptied on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_len  <= '0;
            st_data <= '0;
        end else if (load) begin
            st_len  <= wr_len;
            st_data <= wr_data;
        end else if (clear) begin
            st_len  <= '0;
        end
    end
endmodule

// File: rtl/hdr_drain.sv
// Byte pusher: shifts a committed header out one byte per cycle, low byte first.
// Assumes load is only raised while idle (busy low).
module hdr_drain #(
    parameter int MAX_BYTES = 4,
    parameter int BYTE_W    = 8,
    localparam int DATA_W   = MAX_BYTES * BYTE_W,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_len,
    input  logic [DATA_W-1:0] load_data,
    output logic              push_valid,
    output logic [BYTE_W-1:0] push_data,
    output logic              busy
);
    logic [CNT_W-1:0]  left;
    logic [DATA_W-1:0] shreg;

    // Load a header or advance by one byte per pushed cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left  <= '0;
            shreg <= '0;
        end else if (load) begin
            left  <= load_len;
            shreg <= load_data;
        end else if (left != '0) begin
            left  <= left - CNT_W'(1);
            shreg <= shreg >> BYTE_W;
        end
    end

    assign busy       = (left != '0);
    assign push_valid = busy;
    assign push_data  = shreg[BYTE_W-1:0];
endmodule

// File: rtl/hdr_commit_ctrl.sv
// Header commit controller (top). Decides whether header writes are staged,
// committed or refused, based on the synchronised chip select and the gating
// mode, and keeps the sticky committed / ignored flags.
// Assumes a single clock domain apart from cs_n_in, and a push sink that is
// always ready.
module hdr_commit_ctrl
    import hdr_commit_pkg::*;
#(
    parameter int MAX_BYTES   = 4,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int DATA_W     = MAX_BYTES * BYTE_W,
    localparam int CNT_W      = $clog2(MAX_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n_in,
    input  logic [MAX_BYTES-1:0] hdr_wr,
    input  logic [DATA_W-1:0]    hdr_wdata,
    input  logic                 ctl_wr,
    input  logic [CTL_W-1:0]     ctl_wdata,
    output logic [CTL_W-1:0]     stat,
    output logic                 push_valid,
    output logic [BYTE_W-1:0]    push_data
);
    logic              cs_n_q, cs_fall, cs_low;
    logic              wr_any, busy;
    logic [CNT_W-1:0]  wr_len, st_len;
    logic [DATA_W-1:0] st_data;
    logic              gate, en, done, drop;
    logic              blocked, wr_accept, wr_ignore;
    logic              imm_commit, fall_commit, arm_commit, commit;
    logic              stage_load;
    logic [CNT_W-1:0]  drain_len;
    logic [DATA_W-1:0] drain_data;

    hdr_cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n_async(cs_n_in),
        .cs_n_q(cs_n_q), .cs_fall(cs_fall)
    );

    hdr_stage #(.MAX_BYTES(MAX_BYTES), .BYTE_W(BYTE_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_strobe(hdr_wr), .wr_data(hdr_wdata),
        .load(stage_load), .clear(commit),
        .wr_any(wr_any), .wr_len(wr_len), .st_len(st_len), .st_data(st_data)
    );

    hdr_drain #(.MAX_BYTES(MAX_BYTES), .BYTE_W(BYTE_W)) u_drain (
        .clk(clk), .rst_n(rst_n), .load(commit), .load_len(drain_len),
        .load_data(drain_data), .push_valid(push_valid),
        .push_data(push_data), .busy(busy)
    );

    assign cs_low = ~cs_n_q;

    // Accept/refuse decision and the three commit sources.
    always_comb begin
        blocked     = done | busy | (gate & cs_low);
        wr_accept   = wr_any & ~blocked;
        wr_ignore   = wr_any & blocked;
        imm_commit  = ~gate & wr_accept & cs_low;
        fall_commit = ~gate & cs_fall & (st_len != '0) & ~done & ~busy;
        arm_commit  = gate & en & cs_low & ~done & ~busy;
        commit      = imm_commit | fall_commit | arm_commit;
        stage_load  = wr_accept & ~imm_commit;
        drain_len   = imm_commit ? wr_len    : st_len;
        drain_data  = imm_commit ? hdr_wdata : st_data;
    end

    // Mode, enable and sticky flags; setting events win over clear-by-0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate <= 1'b0;
            en   <= 1'b0;
            done <= 1'b0;
            drop <= 1'b0;
        end else begin
            if (ctl_wr) begin
                gate <= ctl_wdata[BIT_GATE];
                en   <= ctl_wdata[BIT_EN];
            end
            if (!gate && wr_any)
                en <= 1'b1;
            if (commit)
                done <= 1'b1;
            else if (ctl_wr && !ctl_wdata[BIT_DONE])
                done <= 1'b0;
            if (wr_ignore)
                drop <= 1'b1;
            else if (ctl_wr && !ctl_wdata[BIT_DROP])
                drop <= 1'b0;
        end
    end

    always_comb begin
        stat           = '0;
        stat[BIT_GATE] = gate;
        stat[BIT_EN]   = en;
        stat[BIT_DONE] = done;
        stat[BIT_DROP] = drop;
    end
endmodule

// File: rtl/hdr_commit_ctrl_chk.sv
// Port-level assertions for hdr_commit_ctrl, attached by bind.
module hdr_commit_ctrl_chk
    import hdr_commit_pkg::*;
#(
    parameter int MAX_BYTES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ctl_wr,
    input logic                 clr_done_w,
    input logic                 clr_drop_w,
    input logic [MAX_BYTES-1:0] hdr_wr,
    input logic [CTL_W-1:0]     stat,
    input logic                 push_valid
);
    // R1: first cycle out of reset shows the cleared state.
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stat == '0 && !push_valid));

    // R10: committed flag falls only through a control write of 0.
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[BIT_DONE] && !(ctl_wr && !clr_done_w)) |=> stat[BIT_DONE]);

    // R10: ignored flag falls only through a control write of 0.
    a_r10_drop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[BIT_DROP] && !(ctl_wr && !clr_drop_w)) |=> stat[BIT_DROP]);

    // R3: a push burst starts only together with a new commit.
    a_r3_push_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push_valid) |-> $rose(stat[BIT_DONE]));

    // R5: free-mode header write sets the enable bit.
    a_r5_auto_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat[BIT_GATE] && hdr_wr != '0 && !ctl_wr) |=> stat[BIT_EN]);

    // R8: gated mode never commits while the enable bit is clear.
    a_r8_gated_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[BIT_GATE] && !stat[BIT_EN] && !stat[BIT_DONE] && !ctl_wr) |=> !stat[BIT_DONE]);
endmodule

bind hdr_commit_ctrl hdr_commit_ctrl_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
    .clr_done_w(ctl_wdata[hdr_commit_pkg::BIT_DONE]),
    .clr_drop_w(ctl_wdata[hdr_commit_pkg::BIT_DROP]),
    .hdr_wr(hdr_wr), .stat(stat), .push_valid(push_valid)
);

// File: tb/hdr_commit_ctrl_test.sv
`timescale 1ns/1ps
module hdr_commit_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n_in = 1'b1;
    logic [3:0]  hdr_wr = '0;
    logic [31:0] hdr_wdata = '0;
    logic        ctl_wr = 1'b0;
    logic [3:0]  ctl_wdata = '0;
    logic [3:0]  stat;
    logic        push_valid;
    logic [7:0]  push_data;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    hdr_commit_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .hdr_wr(hdr_wr),
        .hdr_wdata(hdr_wdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .stat(stat), .push_valid(push_valid), .push_data(push_data)
    );

    // Scenario vector: stat bits are {ignored, committed, enable, gated}.
    typedef struct packed {
        logic        gate;
        logic        en;
        logic        cs1;
        logic        drop;
        logic [3:0]  s1;
        logic [31:0] d1;
        logic [3:0]  s2;
        logic [31:0] d2;
        logic [3:0]  xstat;
        logic [2:0]  xcnt;
        logic [31:0] xword;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b1,1'b1,4'b1000,32'h44332211,4'b0000,32'h0,     4'b0110,3'd4,32'h44332211}, // R6
        '{1'b0,1'b0,1'b0,1'b0,4'b0010,32'h0000BEEF,4'b0000,32'h0,     4'b0110,3'd2,32'h0000BEEF}, // R7
        '{1'b0,1'b0,1'b1,1'b1,4'b0001,32'h000000A5,4'b0100,32'h123456,4'b1110,3'd1,32'h000000A5}, // R9
        '{1'b0,1'b0,1'b1,1'b0,4'b0100,32'h00ABCDEF,4'b0000,32'h0,     4'b0010,3'd0,32'h0},        // R5
        '{1'b1,1'b1,1'b1,1'b1,4'b0010,32'h00005AA5,4'b0000,32'h0,     4'b0111,3'd2,32'h00005AA5}, // R8
        '{1'b1,1'b0,1'b1,1'b1,4'b1000,32'h01020304,4'b0000,32'h0,     4'b0001,3'd0,32'h0},        // R8
        '{1'b1,1'b1,1'b0,1'b0,4'b0001,32'h00000077,4'b0000,32'h0,     4'b1111,3'd0,32'h0},        // R9
        '{1'b1,1'b0,1'b0,1'b0,4'b0001,32'h00000066,4'b0000,32'h0,     4'b1001,3'd0,32'h0},        // R8
        '{1'b1,1'b1,1'b1,1'b1,4'b0100,32'h00C0FFEE,4'b0001,32'h11,    4'b1111,3'd3,32'h00C0FFEE}, // R9
        '{1'b0,1'b0,1'b0,1'b0,4'b0011,32'hAABBCCDD,4'b0000,32'h0,     4'b0110,3'd2,32'h0000CCDD}, // R2
        '{1'b1,1'b1,1'b1,1'b0,4'b0001,32'h00000042,4'b0000,32'h0,     4'b0011,3'd0,32'h0}         // R8
    };

    // Collector of pushed bytes, assembled low byte first.
    logic        coll_clr = 1'b1;
    logic [31:0] coll_word;
    int          coll_n;
    always @(negedge clk) begin
        if (coll_clr) begin
            coll_word <= '0;
            coll_n    <= 0;
        end else if (push_valid) begin
            coll_word <= coll_word | (32'(push_data) << (8 * coll_n));
            coll_n    <= coll_n + 1;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic cs);
        rst_n   = 1'b0;
        cs_n_in = cs;
        hdr_wr  = '0;
        ctl_wr  = 1'b0;
        ticks(2);
        rst_n = 1'b1;
    endtask

    task automatic ctl(input logic [3:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        tick();
        ctl_wr = 1'b0;
    endtask

    task automatic hwrite(input logic [3:0] s, input logic [31:0] d);
        hdr_wr = s; hdr_wdata = d;
        tick();
        hdr_wr = '0;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        string tag;
        coll_clr = 1'b1;
        do_reset(v.cs1);
        coll_clr = 1'b0;
        ctl({2'b00, v.en, v.gate});
        ticks(4);
        hwrite(v.s1, v.d1);
        if (v.drop) begin
            cs_n_in = 1'b0;
            ticks(4);
        end
        if (v.s2 != 0) hwrite(v.s2, v.d2);
        ticks(6);
        tag = $sformatf("R10 vec%0d stat", idx);
        chk(tag, 32'(stat), 32'(v.xstat));
        tag = $sformatf("R3 vec%0d byte count", idx);
        chk(tag, 32'(coll_n), 32'(v.xcnt));
        tag = $sformatf("R2 vec%0d header word", idx);
        chk(tag, coll_word, v.xword);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state.
        do_reset(1'b1);
        tick();
        chk("R1 stat after reset", 32'(stat), 32'h0);
        chk("R1 push_valid after reset", 32'(push_valid), 32'h0);

        // Table-driven scenarios (R2 R5 R6 R7 R8 R9 R10).
        for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

        // R10: clear-by-0, starting from the third scenario (free mode, cs low, both flags set).
        run_vec(VEC[2], 2);
        ctl(4'b0110);
        chk("R10 ignored cleared, committed kept", 32'(stat), 32'h6);
        ctl(4'b0010);
        chk("R10 committed cleared", 32'(stat), 32'h2);
        // R7: with the flag cleared and cs low, the next write is committed at once.
        hwrite(4'b0001, 32'h0000009C);
        chk("R7 immediate commit stat", 32'(stat), 32'h6);
        chk("R7 immediate push valid", 32'(push_valid), 32'h1);
        chk("R7 immediate push data", 32'(push_data), 32'h9C);
        tick();
        chk("R3 single byte ends", 32'(push_valid), 32'h0);

        // R3: byte order and burst length; R9: write during push is refused.
        ctl(4'b0010);
        hwrite(4'b0100, 32'h00332211);
        chk("R3 byte0", 32'(push_data), 32'h11);
        chk("R3 byte0 valid", 32'(push_valid), 32'h1);
        ctl(4'b0010);
        chk("R3 byte1", 32'(push_data), 32'h22);
        hwrite(4'b0001, 32'h000000EE);
        chk("R9 refused while pushing", 32'(stat), 32'hA);
        chk("R3 byte2", 32'(push_data), 32'h33);
        tick();
        chk("R3 burst over", 32'(push_valid), 32'h0);

        // R4: synchroniser latency in gated mode.
        do_reset(1'b1);
        ctl(4'b0011);
        hwrite(4'b0001, 32'h0000003C);
        cs_n_in = 1'b0;
        ticks(2);
        chk("R4 no commit after two edges", 32'(stat[2]), 32'h0);
        tick();
        chk("R4 commit on third edge", 32'(stat[2]), 32'h1);
        chk("R4 staged byte pushed", 32'(push_data), 32'h3C);
        chk("R8 gated push valid", 32'(push_valid), 32'h1);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule